// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead Time and Trap

The block drives three half-bridges. A shared up-counter sets the carrier period, and each of the three channels compares the counter with its own duty value to decide whether the high-side switch of its bridge should conduct. A per-channel state machine turns that request into a complementary pair of gate signals. It inserts a programmable gap with both switches off whenever conduction passes from one side to the other. The six gate signals then pass through per-pin polarity selection and a shutdown stage.

The counter advances on every system clock or only on rising edges of an encoder input, as software selects. Duty values are written into shadow storage and take effect only when the counter wraps, so a period never mixes old and new duty. An active-low trap input drives every gate pin to its inactive level through combinational logic, with no clock edge needed. The trap also sets a sticky flag. The flag keeps the pins off until software pulses a clear input while the trap input is high.

Each channel's state machine has four states. `DB_LO` has the low side conducting. `DB_GAP_UP` has both sides off on the way to the high side. `DB_HI` has the high side conducting. `DB_GAP_DN` has both sides off on the way to the low side. Transitions:
- `DB_LO`→`DB_GAP_UP` when high side is requested and the dead time is nonzero.
- `DB_LO`→`DB_HI` directly when the dead time is zero.
- `DB_GAP_UP`→`DB_HI` when the gap count expires.
- `DB_GAP_UP`→`DB_LO` when the request drops before the gap ends.
- `DB_HI`, `DB_GAP_DN` and their transitions mirror the above.

Top module: `cpwm3_top`

## Requirements
- R1: The counter runs 0 up to `period` and then wraps to 0, so one carrier period lasts `period`+1 ticks. A channel requests its high side while the count is below that channel's active duty. Duty 0 never requests it.
- R2: With dead time 0, each channel's low side is active exactly when its high side is not. Over one period the two active counts sum to `period`+1.
- R3: With dead time N>0, each passage between sides holds both outputs of the pair inactive for N system clocks. The two outputs of a pair are never active together.
- R4: If a request lasts no longer than the dead time, the side being turned on stays inactive for that whole pulse.
- R5: A duty write lands in a shadow value. The value used for comparison takes the shadow only at the tick where the counter wraps. With the timer stopped (`run`=0), a duty write has no effect on the outputs.
- R6: A polarity bit of 0 makes a pin high when its side is active. A bit of 1 makes it low when active. In both cases the inactive level equals the polarity bit.
- R7: While `trap_n` is 0, every gate pin shows its inactive level, combinationally and without waiting for a clock edge.
- R8: A trap sets `trap_flag`, which keeps all pins inactive after `trap_n` returns high. A `trap_clr` pulse clears the flag only while `trap_n` is 1.
- R9: With `clk_sel`=1 the counter advances once per rising edge of `enc_in` and holds otherwise. With `clk_sel`=0 it advances every clock while `run`=1.
- R10: After reset, every channel is in `DB_LO` (low side active, high side inactive), and `trap_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timer enable |
| clk_sel | input | 1 | Timer source: 0 system clock, 1 encoder edges |
| enc_in | input | 1 | Position encoder pulse input (asynchronous) |
| period | input | 16 | Last count value of a carrier period |
| dead_time | input | 8 | Both-off gap in system clocks, 0 disables |
| duty_wr | input | 1 | Write strobe for a shadow duty value |
| duty_ch | input | 2 | Channel selected by the write |
| duty_val | input | 16 | Duty value written |
| pol_hi | input | 3 | Polarity of the high-side pins |
| pol_lo | input | 3 | Polarity of the low-side pins |
| trap_n | input | 1 | Asynchronous active-low shutdown |
| trap_clr | input | 1 | Clears the latched trap flag |
| pin_hi | output | 3 | High-side gate pins, one per channel |
| pin_lo | output | 3 | Low-side gate pins, one per channel |
| trap_flag | output | 1 | Latched trap indication |

## Verification
The hardest state to reach from the ports is the aborted dead-time gap, where a request drops before its gap expires. The bench sets a dead time longer than a two-count duty, then counts active cycles over a full period. It expects no high-side activity, and a low side that is missing only for the short pulse. The encoder-clocked case is awkward because counting depends on a slow, asynchronous input. The bench first loads a four-count period under the system clock, then switches sources and samples once after each hand-made encoder pulse, so every count value is visited in turn. The trap is asserted midway between clock edges, and the pins are checked before the next edge arrives.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    typedef enum logic [1:0] {
        DB_LO     = 2'd0,
        DB_GAP_UP = 2'd1,
        DB_HI     = 2'd2,
        DB_GAP_DN = 2'd3
    } db_state_t;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_enc,
    input  logic             enc_in,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             boundary
);
    logic [2:0]       enc_sh;
    logic             enc_rise;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;

    // two-stage synchroniser plus one stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) enc_sh <= '0;
        else        enc_sh <= {enc_sh[1:0], enc_in};
    end

    assign enc_rise = enc_sh[1] & ~enc_sh[2];
    assign tick     = run & (src_enc ? enc_rise : 1'b1);
    assign boundary = tick & (cnt_q >= period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (boundary) cnt_q <= '0;
        else if (tick)     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (cnt_q == '0));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
endmodule

// File: rtl/cpwm_duty_bank.sv
module cpwm_duty_bank #(
    parameter int NCH   = 3,
    parameter int CNT_W = 16,
    parameter int CH_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             boundary,
    input  logic [CNT_W-1:0] cnt,
    output logic [NCH-1:0]   req_hi
);
    logic [NCH-1:0][CNT_W-1:0] shadow_q;
    logic [NCH-1:0][CNT_W-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (wr && (wr_ch == CH_W'(i))) shadow_q[i] <= wr_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        active_q <= '0;
        else if (boundary) active_q <= shadow_q;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        assign req_hi[g] = (cnt < active_q[g]);
    end

    p_buffer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(active_q));
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [DT_W-1:0] dead,
    output logic            hi_act,
    output logic            lo_act
);
    import cpwm_pkg::*;

    db_state_t       state_q, state_d;
    logic [DT_W-1:0] gap_q, gap_d;

    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        unique case (state_q)
            DB_LO: begin
                if (req) begin
                    if (dead == '0) begin
                        state_d = DB_HI;
                    end else begin
                        state_d = DB_GAP_UP;
                        gap_d   = dead;
                    end
                end
            end
            DB_GAP_UP: begin
                if (!req)              state_d = DB_LO;
                else if (gap_q <= 1)   state_d = DB_HI;
                else                   gap_d   = gap_q - 1'b1;
            end
            DB_HI: begin
                if (!req) begin
                    if (dead == '0) begin
                        state_d = DB_LO;
                    end else begin
                        state_d = DB_GAP_DN;
                        gap_d   = dead;
                    end
                end
            end
            DB_GAP_DN: begin
                if (req)               state_d = DB_HI;
                else if (gap_q <= 1)   state_d = DB_LO;
                else                   gap_d   = gap_q - 1'b1;
            end
            default: state_d = DB_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_LO;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    always_comb begin
        hi_act = (state_q == DB_HI);
        lo_act = (state_q == DB_LO);
    end

    p_gap_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DB_LO && dead != '0) |=> (state_q != DB_HI));
    p_gap_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DB_HI && dead != '0) |=> (state_q != DB_LO));
    p_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DB_GAP_UP && !req) |=> (state_q == DB_LO));
endmodule

// File: rtl/cpwm_trap.sv
module cpwm_trap (
    input  logic clk,
    input  logic rst_n,
    input  logic trap_n,
    input  logic clr,
    output logic force_off,
    output logic latched
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n or negedge trap_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (!trap_n) flag_q <= 1'b1;
        else if (clr)     flag_q <= 1'b0;
    end

    assign force_off = ~trap_n | flag_q;
    assign latched   = flag_q;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !trap_n) |=> flag_q);
endmodule

// File: rtl/cpwm3_top.sv
module cpwm3_top #(
    parameter int NCH   = 3,
    parameter int CNT_W = 16,
    parameter int DT_W  = 8,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clk_sel,
    input  logic             enc_in,
    input  logic [CNT_W-1:0] period,
    input  logic [DT_W-1:0]  dead_time,
    input  logic             duty_wr,
    input  logic [CH_W-1:0]  duty_ch,
    input  logic [CNT_W-1:0] duty_val,
    input  logic [NCH-1:0]   pol_hi,
    input  logic [NCH-1:0]   pol_lo,
    input  logic             trap_n,
    input  logic             trap_clr,
    output logic [NCH-1:0]   pin_hi,
    output logic [NCH-1:0]   pin_lo,
    output logic             trap_flag
);
    logic [CNT_W-1:0] cnt;
    logic             boundary;
    logic [NCH-1:0]   req_hi;
    logic [NCH-1:0]   hi_act;
    logic [NCH-1:0]   lo_act;
    logic             force_off;

    cpwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run), .src_enc(clk_sel),
        .enc_in(enc_in), .period(period), .cnt(cnt), .boundary(boundary)
    );

    cpwm_duty_bank #(.NCH(NCH), .CNT_W(CNT_W), .CH_W(CH_W)) u_duty (
        .clk(clk), .rst_n(rst_n), .wr(duty_wr), .wr_ch(duty_ch),
        .wr_val(duty_val), .boundary(boundary), .cnt(cnt), .req_hi(req_hi)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cpwm_deadband #(.DT_W(DT_W)) u_db (
            .clk(clk), .rst_n(rst_n), .req(req_hi[g]), .dead(dead_time),
            .hi_act(hi_act[g]), .lo_act(lo_act[g])
        );
        assign pin_hi[g] = force_off ? pol_hi[g] : (hi_act[g] ^ pol_hi[g]);
        assign pin_lo[g] = force_off ? pol_lo[g] : (lo_act[g] ^ pol_lo[g]);
    end

    cpwm_trap u_trap (
        .clk(clk), .rst_n(rst_n), .trap_n(trap_n), .clr(trap_clr),
        .force_off(force_off), .latched(trap_flag)
    );

    p_trap_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_n |-> (pin_hi == pol_hi && pin_lo == pol_lo));
    p_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_hi ^ pol_hi) & (pin_lo ^ pol_lo)) == '0);
endmodule

// File: tb/sim_cpwm3_top.sv
module sim_cpwm3_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        clk_sel = 1'b0;
    logic        enc_in = 1'b0;
    logic [15:0] period = 16'd31;
    logic [7:0]  dead_time = 8'd0;
    logic        duty_wr = 1'b0;
    logic [1:0]  duty_ch = 2'd0;
    logic [15:0] duty_val = 16'd0;
    logic [2:0]  pol_hi = 3'b000;
    logic [2:0]  pol_lo = 3'b000;
    logic        trap_n = 1'b1;
    logic        trap_clr = 1'b0;
    logic [2:0]  pin_hi;
    logic [2:0]  pin_lo;
    logic        trap_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cpwm3_top u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .clk_sel(clk_sel), .enc_in(enc_in),
        .period(period), .dead_time(dead_time), .duty_wr(duty_wr),
        .duty_ch(duty_ch), .duty_val(duty_val), .pol_hi(pol_hi), .pol_lo(pol_lo),
        .trap_n(trap_n), .trap_clr(trap_clr), .pin_hi(pin_hi), .pin_lo(pin_lo),
        .trap_flag(trap_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_duty(input int ch, input int val);
        @(negedge clk);
        duty_wr = 1'b1; duty_ch = 2'(ch); duty_val = 16'(val);
        @(negedge clk);
        duty_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (2 * (int'(period) + 1) + 8) @(negedge clk);
    endtask

    // counts raw high levels on each pin of one channel, plus overlap of active sides
    task automatic measure(input int ch, input int n, output int hi_n, output int lo_n,
                           output int both_n);
        hi_n = 0; lo_n = 0; both_n = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pin_hi[ch]) hi_n++;
            if (pin_lo[ch]) lo_n++;
            if ((pin_hi[ch] ^ pol_hi[ch]) && (pin_lo[ch] ^ pol_lo[ch])) both_n++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 pin_hi after reset", int'(pin_hi), 0);
        check("R10 pin_lo after reset", int'(pin_lo), 7);
        check("R10 trap_flag after reset", int'(trap_flag), 0);
    endtask

    task automatic t_duty();
        int h, l, b;
        dead_time = 8'd0;
        write_duty(0, 10); write_duty(1, 20); write_duty(2, 0);
        run = 1'b1;
        settle();
        measure(0, 32, h, l, b);
        check("R1 ch0 high count", h, 10);
        check("R2 ch0 low count", l, 22);
        measure(1, 32, h, l, b);
        check("R1 ch1 high count", h, 20);
        check("R2 ch1 low count", l, 12);
        measure(2, 32, h, l, b);
        check("R1 ch2 duty zero high count", h, 0);
        check("R2 ch2 duty zero low count", l, 32);
    endtask

    task automatic t_dead();
        int h, l, b;
        dead_time = 8'd3;
        settle();
        measure(0, 32, h, l, b);
        check("R3 ch0 high count with gap", h, 7);
        check("R3 ch0 low count with gap", l, 19);
        check("R3 ch0 overlap", b, 0);
    endtask

    task automatic t_short();
        int h, l, b;
        dead_time = 8'd5;
        write_duty(0, 2);
        settle();
        measure(0, 32, h, l, b);
        check("R4 short pulse high count", h, 0);
        check("R4 short pulse low count", l, 30);
    endtask

    task automatic t_buffer();
        int h, l, b, changes;
        logic ref_hi;
        dead_time = 8'd0;
        write_duty(0, 10);
        settle();
        run = 1'b0;
        repeat (4) @(negedge clk);
        ref_hi = pin_hi[0];
        write_duty(0, 25);
        changes = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (pin_hi[0] != ref_hi) changes++;
        end
        check("R5 write ignored while stopped", changes, 0);
        run = 1'b1;
        settle();
        measure(0, 32, h, l, b);
        check("R5 shadow loaded at wrap", h, 25);
    endtask

    task automatic t_polarity();
        int h, l, b;
        pol_hi = 3'b001;
        repeat (3) @(negedge clk);
        measure(0, 32, h, l, b);
        check("R6 active-low high side level count", h, 7);
        check("R6 active-high low side", l, 7);
        pol_hi = 3'b000;
    endtask

    task automatic t_trap();
        int h, l, b;
        write_duty(0, 10);
        settle();
        pol_lo = 3'b010;
        @(negedge clk);
        #2 trap_n = 1'b0;
        #1;
        check("R7 pins forced without edge (hi)", int'(pin_hi), 0);
        check("R7 pins forced without edge (lo)", int'(pin_lo), 2);
        @(negedge clk);
        check("R8 flag set", int'(trap_flag), 1);
        trap_clr = 1'b1;
        @(negedge clk);
        trap_clr = 1'b0;
        trap_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R8 clear ignored while trap low", int'(trap_flag), 1);
        check("R8 pins still forced (lo)", int'(pin_lo), 2);
        pol_lo = 3'b000;
        trap_clr = 1'b1;
        @(negedge clk);
        trap_clr = 1'b0;
        @(negedge clk);
        check("R8 flag cleared", int'(trap_flag), 0);
        measure(0, 32, h, l, b);
        check("R8 output resumes", h, 10);
    endtask

    task automatic t_encoder();
        int changes, ones;
        logic ref_hi;
        period = 16'd3;
        write_duty(0, 2);
        repeat (20) @(negedge clk);
        clk_sel = 1'b1;
        repeat (10) @(negedge clk);
        ref_hi = pin_hi[0];
        changes = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (pin_hi[0] != ref_hi) changes++;
        end
        check("R9 counter holds without encoder edges", changes, 0);
        ones = 0;
        for (int p = 0; p < 8; p++) begin
            enc_in = 1'b1;
            repeat (3) @(negedge clk);
            enc_in = 1'b0;
            repeat (5) @(negedge clk);
            if (pin_hi[0]) ones++;
        end
        check("R9 one count per encoder edge", ones, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_duty();
        t_dead();
        t_short();
        t_buffer();
        t_polarity();
        t_trap();
        t_encoder();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule